// File: doc/BRIEF.md
# Serial Key Unlock Security Controller

This block guards access to protected nonvolatile memory behind an eight-byte key. After every reset it collects bytes from a byte-wide receive interface, which a serial receiver outside the block feeds. It compares each byte, as it arrives, with the matching byte of a stored key that is presented on a wide input bus. After the eighth byte it records a single verdict, pass or fail. It also emits a one-cycle request asking the transmitter to send a break character, which tells the host that the device is ready for commands.

The verdict decides two things. It decides whether protected reads return the real array data or a fixed mask value. It also decides whether an instruction fetch from protected memory is allowed or raises an illegal-address reset request. The block has two resets:

- **Power-on reset** clears everything.
- **Warm reset** (any other reset) restarts byte collection but keeps the verdict. An earlier pass stays in force whatever key is sent next. An earlier failure turns into a permanent illegal-address reset request.

Top module: `keylock_ctrl`

## Requirements
- R1: While `rst_por` is high and on the cycle after it, the block is cleared: `done`=0, `brk_req`=0, `unlocked`=0, and `illegal_rst_req` follows `fetch_req`.
- R2: A byte is taken only on a clock edge where `rx_valid`=1. `done` and `brk_req` rise on the edge that takes the eighth byte since the last reset, and not before. `brk_req` is high for exactly one cycle.
- R3: If all eight bytes equal the stored key, `unlocked` goes high one cycle after `brk_req`. From then on, `rd_data_out` equals `rd_data_in` and a fetch raises no `illegal_rst_req`.
- R4: A wrong value in any single byte position, the first and the last included, gives a fail even if every other byte matches. After a fail, `rd_data_out` is `MASK_VAL` (default 8'h00) and `fetch_req`=1 drives `illegal_rst_req`=1.
- R5: Bytes that arrive after `done` is high are ignored. They produce no new `brk_req` and no change in `unlocked`.
- R6: Byte k received after reset (k=0..7) is compared with `key_store[8k+7:8k]`. The first byte sent is therefore bits 7:0.
- R7: After a pass, a warm reset clears `done` but keeps `unlocked`=1. Eight new bytes are needed for the next `brk_req`, and `unlocked` stays 1 whatever their values.
- R8: After a fail, a warm reset makes `illegal_rst_req` stay high on every cycle, with or without a fetch, through further warm resets. Only a power-on reset ends this.
- R9: With every stored key byte at 8'hFF (erased memory), eight 8'hFF bytes give a pass.
- R10: From a power-on reset until a pass, protected reads return `MASK_VAL` and fetches raise `illegal_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_warm | input | 1 | Any other reset, synchronous, active high |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_byte | input | 8 | Received byte |
| key_store | input | 64 | Stored key; byte k in bits 8k+7:8k |
| rd_data_in | input | 8 | Data read from the protected array |
| fetch_req | input | 1 | Instruction fetch from protected memory this cycle |
| rd_data_out | output | 8 | Read data after gating |
| illegal_rst_req | output | 1 | Illegal-address reset request |
| brk_req | output | 1 | One-cycle request to send a break character |
| done | output | 1 | Eight key bytes collected since the last reset |
| unlocked | output | 1 | Access to protected memory granted |

## Verification
The bench sweeps a single flipped bit over all 64 bit positions of the key. A design that compares only some positions, or that lets a later match clear an earlier mismatch, would then unlock. It sends a byte-reversed copy of the correct key, which catches a reversed byte order. It holds `rx_valid` low for several cycles between bytes, which catches a counter that advances without a valid byte, and it sends extra bytes after the eighth to catch a second break request. Warm resets after a pass and after a fail catch a design that loses the pass or lets a failed device run. A design that clears the pass or the failure loop on a warm reset would show `unlocked` dropping or `illegal_rst_req` going quiet.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam int unsigned KL_BYTE_W    = 8;
    localparam int unsigned KL_KEY_BYTES = 8;

    typedef logic [KL_BYTE_W-1:0] kl_byte_t;

    // Result of one completed key collection, valid for a single cycle.
    typedef struct packed {
        logic valid;
        logic match;
    } kl_eval_t;

    // Security state that outlives warm resets.
    typedef struct packed {
        logic unlocked;
        logic failed;
        logic looping;
    } kl_sec_t;

    typedef enum logic [1:0] {
        KL_ACC_DENY  = 2'd0,
        KL_ACC_GRANT = 2'd1,
        KL_ACC_LOOP  = 2'd2
    } kl_access_e;

    function automatic kl_access_e kl_access(input kl_sec_t s);
        if (s.looping)       return KL_ACC_LOOP;
        else if (s.unlocked) return KL_ACC_GRANT;
        else                 return KL_ACC_DENY;
    endfunction

endpackage

// File: rtl/keylock_collector.sv
module keylock_collector
    import keylock_pkg::*;
#(
    parameter int unsigned KEY_BYTES = KL_KEY_BYTES,
    parameter int unsigned BYTE_W    = KL_BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_any,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic [KEY_BYTES*BYTE_W-1:0] key_store,
    output logic                        done,
    output kl_eval_t                    eval
);
    localparam int unsigned CW   = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
    localparam logic [CW-1:0] LAST = CW'(KEY_BYTES - 1);

    logic [CW-1:0]     cnt;
    logic              mism;
    logic [BYTE_W-1:0] exp_byte;
    logic              mism_nxt;
    logic              take;

    assign exp_byte = key_store[cnt*BYTE_W +: BYTE_W];
    assign take     = rx_valid && !done;
    assign mism_nxt = mism | (rx_byte != exp_byte);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            cnt  <= '0;
            mism <= 1'b0;
            done <= 1'b0;
            eval <= '0;
        end else begin
            eval.valid <= 1'b0;
            if (take) begin
                mism <= mism_nxt;
                if (cnt == LAST) begin
                    cnt        <= '0;
                    done       <= 1'b1;
                    eval.valid <= 1'b1;
                    eval.match <= !mism_nxt;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    brk_single_chk: assert property (@(posedge clk) disable iff (rst_any)
        eval.valid |=> !eval.valid);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst_any)
        done |=> done);

    // R2
    eval_needs_done_chk: assert property (@(posedge clk) disable iff (rst_any)
        eval.valid |-> done);

    always_comb begin
        // R2
        cnt_range_chk: assert (rst_any || (int'(cnt) < int'(KEY_BYTES)));
    end

endmodule

// File: rtl/keylock_verdict.sv
module keylock_verdict
    import keylock_pkg::*;
(
    input  logic     clk,
    input  logic     rst_por,
    input  logic     rst_warm,
    input  kl_eval_t eval,
    output kl_sec_t  sec
);
    logic decided;

    assign decided = sec.unlocked | sec.failed;

    always_ff @(posedge clk) begin
        if (rst_por) begin
            sec <= '0;
        end else if (rst_warm) begin
            sec.looping <= sec.failed | sec.looping;
        end else if (eval.valid && !decided) begin
            if (eval.match) sec.unlocked <= 1'b1;
            else            sec.failed   <= 1'b1;
        end
    end

    // R7
    unlock_hold_chk: assert property (@(posedge clk) disable iff (rst_por)
        sec.unlocked |=> sec.unlocked);

    // R8
    loop_hold_chk: assert property (@(posedge clk) disable iff (rst_por)
        sec.looping |=> sec.looping);

    // R4
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst_por)
        !(sec.unlocked && sec.failed));

    // R8
    loop_after_warm_chk: assert property (@(posedge clk) disable iff (rst_por)
        (sec.failed && rst_warm) |=> sec.looping);

endmodule

// File: rtl/keylock_gate.sv
module keylock_gate
    import keylock_pkg::*;
#(
    parameter int unsigned BYTE_W   = KL_BYTE_W,
    parameter logic [BYTE_W-1:0] MASK_VAL = '0
) (
    input  kl_sec_t           sec,
    input  logic [BYTE_W-1:0] rd_data_in,
    input  logic              fetch_req,
    output logic [BYTE_W-1:0] rd_data_out,
    output logic              illegal_rst_req
);
    kl_access_e acc;

    always_comb begin
        acc = kl_access(sec);
        unique case (acc)
            KL_ACC_GRANT: begin
                rd_data_out     = rd_data_in;
                illegal_rst_req = 1'b0;
            end
            KL_ACC_LOOP: begin
                rd_data_out     = MASK_VAL;
                illegal_rst_req = 1'b1;
            end
            default: begin
                rd_data_out     = MASK_VAL;
                illegal_rst_req = fetch_req;
            end
        endcase
    end

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
    import keylock_pkg::*;
#(
    parameter int unsigned KEY_BYTES = KL_KEY_BYTES,
    parameter int unsigned BYTE_W    = KL_BYTE_W,
    parameter logic [BYTE_W-1:0] MASK_VAL = '0
) (
    input  logic                        clk,
    input  logic                        rst_por,
    input  logic                        rst_warm,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic [KEY_BYTES*BYTE_W-1:0] key_store,
    input  logic [BYTE_W-1:0]           rd_data_in,
    input  logic                        fetch_req,
    output logic [BYTE_W-1:0]           rd_data_out,
    output logic                        illegal_rst_req,
    output logic                        brk_req,
    output logic                        done,
    output logic                        unlocked
);
    logic     rst_any;
    kl_eval_t eval;
    kl_sec_t  sec;

    assign rst_any = rst_por | rst_warm;

    keylock_collector #(
        .KEY_BYTES (KEY_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_collect (
        .clk       (clk),
        .rst_any   (rst_any),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .key_store (key_store),
        .done      (done),
        .eval      (eval)
    );

    keylock_verdict u_verdict (
        .clk      (clk),
        .rst_por  (rst_por),
        .rst_warm (rst_warm),
        .eval     (eval),
        .sec      (sec)
    );

    keylock_gate #(
        .BYTE_W   (BYTE_W),
        .MASK_VAL (MASK_VAL)
    ) u_gate (
        .sec             (sec),
        .rd_data_in      (rd_data_in),
        .fetch_req       (fetch_req),
        .rd_data_out     (rd_data_out),
        .illegal_rst_req (illegal_rst_req)
    );

    assign brk_req  = eval.valid;
    assign unlocked = sec.unlocked;

    // R10
    locked_fetch_chk: assert property (@(posedge clk) disable iff (rst_por)
        (!unlocked && fetch_req) |-> illegal_rst_req);

endmodule

// File: tb/test_keylock_ctrl.sv
`timescale 1ns/1ps
module test_keylock_ctrl;

    localparam logic [63:0] KEY  = 64'h0123_4567_89AB_CDEF;
    localparam logic [7:0]  MASK = 8'h00;

    logic        clk = 1'b0;
    logic        rst_por = 1'b1, rst_warm = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [63:0] key_store = KEY;
    logic [7:0]  rd_data_in = 8'hA5;
    logic        fetch_req = 1'b0;
    logic [7:0]  rd_data_out;
    logic        illegal_rst_req, brk_req, done, unlocked;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    keylock_ctrl i_keylock_ctrl (
        .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .key_store(key_store),
        .rd_data_in(rd_data_in), .fetch_req(fetch_req),
        .rd_data_out(rd_data_out), .illegal_rst_req(illegal_rst_req),
        .brk_req(brk_req), .done(done), .unlocked(unlocked)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge clk); rst_por = 1'b1;
        @(negedge clk); rst_por = 1'b0;
    endtask

    task automatic do_warm();
        @(negedge clk); rst_warm = 1'b1;
        @(negedge clk); rst_warm = 1'b0;
    endtask

    // Sends one byte; returns at the negedge after it was taken.
    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_key(input logic [63:0] k);
        for (int i = 0; i < 8; i++) send(k[i*8 +: 8]);
    endtask

    // Checks gating at the current (negedge) point for an expected verdict.
    task automatic chk_gate(input bit pass, input string req);
        fetch_req = 1'b1; #0.1;
        chk(illegal_rst_req == !pass, req, illegal_rst_req, !pass);
        chk(rd_data_out == (pass ? rd_data_in : MASK), req, rd_data_out, pass ? rd_data_in : MASK);
        fetch_req = 1'b0; #0.1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_por = 1'b0;
        // R1 / R10: cleared state
        chk(done == 0 && brk_req == 0 && unlocked == 0, "R1", {done, brk_req, unlocked}, 0);
        chk(illegal_rst_req == 0, "R1", illegal_rst_req, 0);
        chk_gate(0, "R10");

        // R2: seven bytes with idle gaps, no done / break
        for (int i = 0; i < 7; i++) begin
            send(KEY[i*8 +: 8]);
            chk(done == 0 && brk_req == 0, "R2", {done, brk_req}, 0);
            repeat (2) @(negedge clk);
            chk(done == 0 && brk_req == 0, "R2", {done, brk_req}, 0);
        end
        send(KEY[56 +: 8]);
        chk(done == 1 && brk_req == 1, "R2", {done, brk_req}, 2'b11);
        @(negedge clk);
        chk(brk_req == 0, "R2", brk_req, 0);
        // R3: pass
        chk(unlocked == 1, "R3", unlocked, 1);
        chk_gate(1, "R3");

        // R5: extra bytes ignored
        for (int i = 0; i < 3; i++) begin
            send(8'h00);
            chk(brk_req == 0 && unlocked == 1 && done == 1, "R5", {brk_req, unlocked, done}, 3'b011);
        end

        // R7: warm reset after pass
        do_warm();
        chk(done == 0 && unlocked == 1, "R7", {done, unlocked}, 2'b01);
        chk_gate(1, "R7");
        for (int i = 0; i < 7; i++) send(8'h5A);
        chk(brk_req == 0, "R7", brk_req, 0);
        send(8'h5A);
        chk(brk_req == 1, "R7", brk_req, 1);
        @(negedge clk);
        chk(unlocked == 1, "R7", unlocked, 1);

        // R4 / R6: single bit flip sweep over every bit of the key
        for (int p = 0; p < 8; p++) begin
            for (int b = 0; b < 8; b++) begin
                logic [63:0] bad;
                bad = KEY;
                bad[p*8 + b] = ~bad[p*8 + b];
                do_por();
                send_key(bad);
                chk(brk_req == 1, "R4", brk_req, 1);
                @(negedge clk);
                chk(unlocked == 0, "R4", unlocked, 0);
                if (b == 0) chk_gate(0, "R4");
                if (b == 3 && (p == 0 || p == 7)) begin
                    // R8: failure loop after warm reset
                    do_warm();
                    for (int c = 0; c < 4; c++) begin
                        chk(illegal_rst_req == 1, "R8", illegal_rst_req, 1);
                        @(negedge clk);
                    end
                    send_key(KEY);
                    @(negedge clk);
                    do_warm();
                    chk(illegal_rst_req == 1 && unlocked == 0, "R8", {illegal_rst_req, unlocked}, 2'b10);
                    do_por();
                    chk(illegal_rst_req == 0, "R8", illegal_rst_req, 0);
                end
            end
        end

        // R6: byte order matters
        do_por();
        send_key({KEY[7:0], KEY[15:8], KEY[23:16], KEY[31:24],
                  KEY[39:32], KEY[47:40], KEY[55:48], KEY[63:56]});
        @(negedge clk);
        chk(unlocked == 0, "R6", unlocked, 0);
        do_por();
        send_key(KEY);
        @(negedge clk);
        chk(unlocked == 1, "R6", unlocked, 1);

        // R9: erased key
        key_store = '1;
        do_por();
        chk(unlocked == 0, "R9", unlocked, 0);
        send_key('1);
        @(negedge clk);
        chk(unlocked == 1, "R9", unlocked, 1);
        chk_gate(1, "R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule